// File: doc/BRIEF.md
# Periodic Tick Interrupt Unit

This block turns four square-wave taps from a real-time divider chain (32 Hz, 8 Hz, 2 Hz and 1 Hz) into maskable interrupt events. Each tap is brought into the system clock domain through a two-stage synchronizer. A falling edge of a tap sets that source's pending flag, but only while the source's enable bit is 1. The pending flags are ORed into one request line that goes to an external interrupt controller.

Software uses a small register bus to reach an enable register and a pending register. The pending register sits one address above the enable register. The interrupt handler reads the pending register to find out which source or sources fired, then writes 1 to each bit it has handled. If a new falling edge lands in the same cycle as that clear, the edge wins, so no tick is lost.

Top module: `tick_irq_unit`

## Requirements
- R1: The four sources use the same bit positions in `tap_i`, in the enable register and in the pending register: bit 3 is the 32 Hz tap, bit 2 the 8 Hz tap, bit 1 the 2 Hz tap and bit 0 the 1 Hz tap.
- R2: A 1-to-0 change on a tap sets its pending bit. The tap is changed ahead of rising clock edge k, and the bit reads 1 from edge k+2 onward (two synchronizer stages, then the flag register). A rising tap sets nothing.
- R3: While a source's enable bit is 0, a falling edge on its tap leaves the pending bit at 0. All enable bits reset to 0.
- R4: The enable register is at address 0 and the pending register is at address 1. Reads of any other address return 0.
- R5: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged.
- R6: `irq_o` is 1 exactly when at least one pending bit is 1.
- R7: If an enabled falling edge and a write-1 clear of the same pending bit fall in the same cycle, the bit stays 1.
- R8: Register bits 7:4 always read 0, and writes to them are ignored. Reading a register changes no state.
- R9: Synchronous active-low reset clears all pending bits, all enable bits, the synchronizer stages and each tap's stored previous level. A tap held high through reset therefore does not look like a falling edge afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tap_i | input | 4 | Divider taps, asynchronous: [3]=32 Hz, [2]=8 Hz, [1]=2 Hz, [0]=1 Hz |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request: OR of all pending bits |

## Verification
The hardest case to reach from the ports is a write-1 clear that lands in exactly the cycle in which a synchronized falling edge reaches the flag. Behind the tap pin there are two synchronizer flops and the edge detector.

The bench first sets the flag with an earlier edge. It then drops the tap just before a known rising edge and counts two edges. It drives the clear on the following negative edge, so the clear and the detected fall meet at the same rising edge. The same edge counting is used to check that the flag reads 0 after the second edge and 1 after the third.

// File: rtl/tick_irq_pkg.sv
// Shared sizing for the periodic tick interrupt unit.
package tick_irq_pkg;
    localparam int SRC_N   = 4;   // number of divider taps
    localparam int REG_W   = 8;   // register data width
    localparam int ADDR_W  = 4;   // register address width
    localparam int EN_ADDR = 0;   // enable register; pending register is one above
endpackage

// File: rtl/tick_sync.sv
// tick_sync: two-stage synchronizer for N asynchronous level signals.
// Assumes each input is a slow square wave (many clocks per level), so
// per-bit synchronization without a gray or handshake scheme is adequate.
module tick_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stage1_q;
    logic [N-1:0] stage2_q;

    // Purpose: shift the raw taps through two flops; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/tick_fall_det.sv
// tick_fall_det: flags a 1-to-0 transition of each synchronized tap.
// Assumes its input is already in the clk domain. The previous-level
// register resets to 0, so a tap that is high at reset is seen as a rise.
module tick_fall_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;

    // Purpose: remember last cycle's level of every tap.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    // Purpose: a fall is previous-high and now-low.
    always_comb begin
        fall_o = prev_q & ~level_i;
    end
endmodule

// File: rtl/tick_flag_bank.sv
// tick_flag_bank: one pending flag per source. A flag is set by an enabled
// fall pulse and cleared by a write-1 pulse; when both arrive together the
// set wins. Assumes fall_i and clr_i are single-cycle pulses in the clk domain.
module tick_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fall_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic set_w;
        assign set_w = fall_i[g] & en_i[g];

        // Purpose: update one pending bit, giving a new event priority over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q[g] <= 1'b0;
            else if (set_w)    flag_q[g] <= 1'b1;
            else if (clr_i[g]) flag_q[g] <= 1'b0;
        end

        // R2
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[g]) |-> $past(fall_i[g] && en_i[g]));

        // R3
        mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_i[g] && !flag_q[g]) |=> !flag_q[g]);

        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fall_i[g] && en_i[g] && clr_i[g]) |=> flag_q[g]);

        // R5
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !(fall_i[g] && en_i[g])) |=> !flag_q[g]);
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/tick_regif.sv
// tick_regif: register bus decode for the enable and pending registers.
// The enable register is at EN_A and the pending register at EN_A+1. A write
// to the pending register produces a one-cycle clear pulse per 1 bit.
// Reads are combinational and have no side effects. Bits above N read 0.
module tick_regif #(
    parameter int N      = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int EN_A   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N-1:0]      flag_i,
    output logic [N-1:0]      en_o,
    output logic [N-1:0]      clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] EN_SEL  = ADDR_W'(EN_A);
    localparam logic [ADDR_W-1:0] PND_SEL = ADDR_W'(EN_A + 1);

    logic         hit_en;
    logic         hit_pnd;
    logic [N-1:0] en_q;

    assign hit_en  = (addr_i == EN_SEL);
    assign hit_pnd = (addr_i == PND_SEL);

    // Purpose: hold the enable bits; only the low N data bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)              en_q <= '0;
        else if (wr_i && hit_en) en_q <= wdata_i[N-1:0];
    end

    // Purpose: turn a write to the pending register into clear pulses.
    always_comb begin
        clr_o = (wr_i && hit_pnd) ? wdata_i[N-1:0] : '0;
    end

    // Purpose: read mux; unmapped addresses and unused bits read 0.
    always_comb begin
        if (hit_en)       rdata_o = DATA_W'(en_q);
        else if (hit_pnd) rdata_o = DATA_W'(flag_i);
        else              rdata_o = '0;
    end

    assign en_o = en_q;

    // R8
    rdata_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:N] == '0);
endmodule

// File: rtl/tick_irq_unit.sv
// tick_irq_unit: top level. Synchronizes four divider taps, detects their
// falling edges, latches enabled events into pending flags and ORs the flags
// into one request. Assumes the taps are much slower than clk.
module tick_irq_unit
    import tick_irq_pkg::*;
#(
    parameter int N      = SRC_N,
    parameter int ADDR_W = tick_irq_pkg::ADDR_W,
    parameter int DATA_W = REG_W,
    parameter int EN_A   = EN_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      tap_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic [N-1:0] tap_s;
    logic [N-1:0] fall_w;
    logic [N-1:0] en_w;
    logic [N-1:0] clr_w;
    logic [N-1:0] flag_w;

    tick_sync #(.N(N)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(tap_i), .sync_o(tap_s)
    );

    tick_fall_det #(.N(N)) u_fall (
        .clk(clk), .rst_n(rst_n), .level_i(tap_s), .fall_o(fall_w)
    );

    tick_flag_bank #(.N(N)) u_flags (
        .clk(clk), .rst_n(rst_n), .fall_i(fall_w), .en_i(en_w),
        .clr_i(clr_w), .flag_o(flag_w)
    );

    tick_regif #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_A(EN_A)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(reg_addr_i), .wr_i(reg_wr_i),
        .wdata_i(reg_wdata_i), .flag_i(flag_w), .en_o(en_w),
        .clr_o(clr_w), .rdata_o(reg_rdata_o)
    );

    // Purpose: one shared request line for every pending source.
    always_comb begin
        irq_o = |flag_w;
    end

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(|clr_w)) |=> irq_o);
endmodule

// File: tb/sim_tick_irq_unit.sv
module sim_tick_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tap = 4'h0;
    logic [3:0] addr = 4'h0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    localparam logic [3:0] A_EN  = 4'd0;
    localparam logic [3:0] A_PND = 4'd1;

    // {enable, tap high pattern, tap low pattern, expected pending}
    localparam logic [15:0] VEC [8] = '{
        16'hFF0F, 16'h1F01, 16'h8F08, 16'hF505,
        16'hFA28, 16'h0F00, 16'h6F96, 16'hF3F0
    };

    tick_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .tap_i(tap), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        addr = a; wr = 1'b0;
        #2 d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] d2;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R9 R3: reset state
        rd_reg(A_EN, d);  check("R9/R3 enable reset", d, 8'h00);
        rd_reg(A_PND, d); check("R9 pending reset", d, 8'h00);
        check("R6 irq at reset", {7'd0, irq}, 8'h00);

        // Vector table: R1 R2 R3 R6
        for (int v = 0; v < 8; v++) begin
            wr_reg(A_EN, 8'h00);
            tap = VEC[v][11:8];
            idle(5);
            wr_reg(A_PND, 8'h0F);
            wr_reg(A_EN, {4'h0, VEC[v][15:12]});
            tap = VEC[v][7:4];
            idle(5);
            rd_reg(A_PND, d);
            check("R1/R2/R3 vector pending", d, {4'h0, VEC[v][3:0]});
            check("R6 vector irq", {7'd0, irq}, {7'd0, |VEC[v][3:0]});
        end

        // R4: map and unmapped address
        wr_reg(A_EN, 8'h05);
        rd_reg(A_EN, d);  check("R4 enable address", d, 8'h05);
        rd_reg(4'd2, d);  check("R4 unmapped read", d, 8'h00);
        rd_reg(4'd15, d); check("R4 unmapped read high", d, 8'h00);

        // R8: upper bits ignored
        wr_reg(A_EN, 8'hFF);
        rd_reg(A_EN, d);  check("R8 upper bits", d, 8'h0F);

        // R2 latency: fall ahead of edge k, flag at edge k+2
        wr_reg(A_PND, 8'h0F);
        tap = 4'hF; idle(5);
        @(negedge clk); tap[0] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); rd_reg(A_PND, d); check("R2 not yet set", d, 8'h00);
        @(posedge clk);
        @(negedge clk); rd_reg(A_PND, d); check("R2 set at third edge", d, 8'h01);

        // R8: read has no side effect
        rd_reg(A_PND, d); idle(1); rd_reg(A_PND, d2);
        check("R8 reread pending", d2, d);

        // R5: write 0 keeps, write 1 clears
        wr_reg(A_PND, 8'h00);
        rd_reg(A_PND, d); check("R5 write 0 keeps", d, 8'h01);
        check("R6 irq while pending", {7'd0, irq}, 8'h01);
        wr_reg(A_PND, 8'h01);
        rd_reg(A_PND, d); check("R5 write 1 clears", d, 8'h00);
        check("R6 irq after clear", {7'd0, irq}, 8'h00);

        // R7: clear in same cycle as the fall reaches the flag
        tap[0] = 1'b1; idle(4);
        tap[0] = 1'b0; idle(5);   // sets bit 0 first
        tap[0] = 1'b1; idle(5);
        rd_reg(A_PND, d); check("R7 precondition", d, 8'h01);
        @(negedge clk); tap[0] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk); addr = A_PND; wdata = 8'h01; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        rd_reg(A_PND, d); check("R7 set wins over clear", d, 8'h01);

        // R9: reset mid-run, taps held high through it
        tap = 4'hF; idle(5);
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        rd_reg(A_PND, d); check("R9 pending cleared", d, 8'h00);
        rd_reg(A_EN, d);  check("R9 enable cleared", d, 8'h00);
        wr_reg(A_EN, 8'h0F);
        idle(5);
        rd_reg(A_PND, d); check("R9 no false fall after reset", d, 8'h00);
        tap = 4'h0; idle(5);
        rd_reg(A_PND, d); check("R9 edge detected after reset", d, 8'h0F);

        done = 1'b1;
        finish_run();
    end
endmodule